// File: doc/BRIEF.md
# Streaming Laplacian Edge Binarizer

The block takes a grayscale image in raster order, one pixel per accepted transfer, and returns a one-bit edge map of the same size in the same order. Two row stores hold the previous two image rows. Together with a few column registers they give the centre pixel and its four orthogonal neighbours. For each interior pixel the block forms a cross-shaped Laplacian response from shifts and adds only, then compares it with a signed threshold. The result is a hard edge / no-edge bit. In an 8-bit pixel view a set bit stands for 255 and a clear bit for 0. The recommended threshold is 30.

Both the pixel input and the edge output use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. The block holds its output steady for as long as the consumer stalls, and it lowers `in_ready` while its single output register is full and not being taken. Because each result needs the pixel below it, the output lags the input by one image row plus one pixel. After the last pixel of a frame, the block flushes the remaining results on its own, with input closed. Image width, height and pixel width are parameters.

Top module: `edge_binarizer`

## Requirements
- R1: For the pixel at row r, column c, the response is the signed value 4·p(r,c) − (p(r−1,c) + p(r+1,c) + p(r,c−1) + p(r,c+1)). It is formed without multipliers and is never outside ±4·(2^PIX_W − 1).
- R2: An interior pixel gives `out_edge` = 1 exactly when its response is greater than or equal to the signed `thresh` input, so a response equal to the threshold is an edge. Otherwise it gives 0.
- R3: Every frame yields exactly IMG_W·IMG_H results in raster order (row 0 first, column 0 first within a row). A result on row 0, row IMG_H−1, column 0 or column IMG_W−1 is always 0.
- R4: `out_sof` is 1 on the first result of each frame (row 0, column 0) and 0 on every other result.
- R5: With the output free, the result for raster index j is presented (`out_valid` high) in the cycle after the input with index j+IMG_W+1 is accepted. After the last pixel of a frame, `in_ready` goes low, and the remaining IMG_W+1 results are produced one per free output cycle.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_edge` and `out_sof` hold their values, and `in_ready` is 0.
- R7: An accepted pixel with `in_sof` = 1 is raster index 0 of a new frame, even in the middle of a frame. The unfinished frame is abandoned, and results it has already produced are kept.
- R8: While no frame is open (after reset, or once a frame's flush has completed), pixels without `in_sof` are accepted and produce no result.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh | input | PIX_W+3 | Signed edge threshold, held constant within a frame (30 recommended) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | PIX_W | Unsigned grayscale pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| out_valid | output | 1 | Edge result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_edge | output | 1 | 1 = edge, 0 = no edge |
| out_sof | output | 1 | Marks the first result of a frame |

## Verification
A result becomes visible one register stage after the accept edge of the input pixel that completes its neighbourhood, IMG_W+1 accepted pixels later. The final IMG_W+1 results of a frame come from the flush and appear one per cycle in which the output is free. The bench keeps an ordered queue of expected results, computed from the image and threshold at the moment each frame starts. It compares a result only on an edge where the handshake completes, so random ready and valid gaps cannot shift the comparison. A directed frame with no gaps and a permanently ready consumer confirms the exact lag: the first result must show up at the same sampled cycle count as the accept of input index IMG_W+1. Stall cases are checked by sampling the held output over several cycles with ready low.

// File: rtl/ebin_pkg.sv
`timescale 1ns/1ps
package ebin_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // Accepted-pixel lag between an input index and the result it completes.
  function automatic int pix_lag(input int img_w);
    return img_w + 1;
  endfunction

  // Largest response magnitude for a given pixel width.
  function automatic int resp_peak(input int pix_w);
    return 4 * ((1 << pix_w) - 1);
  endfunction

endpackage

// File: rtl/ebin_line_buf.sv
`timescale 1ns/1ps
module ebin_line_buf #(
  parameter int DEPTH = 20,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Read returns the stored value before this cycle's write lands.
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

endmodule

// File: rtl/ebin_line_store.sv
`timescale 1ns/1ps
module ebin_line_store #(
  parameter int DEPTH = 20,
  parameter int DW    = 8,
  parameter int ROWS  = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            col,
  input  logic [DW-1:0]            pix,
  output logic [ROWS-1:0][DW-1:0]  above
);

  // above[0] is one row up, above[1] two rows up, and so on.
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    logic [DW-1:0] wd;
    if (k == 0) begin : g_first
      assign wd = pix;
    end else begin : g_chain
      assign wd = above[k-1];
    end
    ebin_line_buf #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_buf (
      .clk   (clk),
      .we    (we),
      .addr  (col),
      .wdata (wd),
      .rdata (above[k])
    );
  end

endmodule

// File: rtl/ebin_cross_eval.sv
`timescale 1ns/1ps
module ebin_cross_eval #(
  parameter int DW = 8,
  parameter int RW = DW + 3
) (
  input  logic [DW-1:0]        up,
  input  logic [DW-1:0]        left,
  input  logic [DW-1:0]        ctr,
  input  logic [DW-1:0]        right,
  input  logic [DW-1:0]        down,
  input  logic signed [RW-1:0] thr,
  output logic signed [RW-1:0] resp,
  output logic                 hit
);

  logic signed [RW-1:0] ctr_x4;
  logic signed [RW-1:0] ring;
  logic signed [RW-1:0] pair_v;
  logic signed [RW-1:0] pair_h;

  always_comb begin
    ctr_x4 = $signed(RW'({ctr, 2'b00}));
    pair_v = $signed(RW'(up)) + $signed(RW'(down));
    pair_h = $signed(RW'(left)) + $signed(RW'(right));
    ring   = pair_v + pair_h;
    resp   = ctr_x4 - ring;
    hit    = (resp >= thr);
  end

endmodule

// File: rtl/ebin_scan_ctrl.sv
`timescale 1ns/1ps
module ebin_scan_ctrl
  import ebin_pkg::*;
#(
  parameter int IMG_W = 20,
  parameter int IMG_H = 12,
  parameter int CW    = $clog2(IMG_W),
  parameter int RWD   = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          slot_free,
  output logic          in_ready,
  output logic          lb_we,
  output logic [CW-1:0] cur_col,
  output logic          emit,
  output logic          emit_zero,
  output logic          emit_border,
  output logic          emit_first
);

  localparam int            LAG      = pix_lag(IMG_W);
  localparam int            DRW      = $clog2(LAG + 1);
  localparam logic [CW-1:0]  LAST_COL = CW'(IMG_W - 1);
  localparam logic [RWD-1:0] LAST_ROW = RWD'(IMG_H - 1);

  phase_e         phase_q;
  logic [CW-1:0]  icol_q, ocol_q;
  logic [RWD-1:0] irow_q, orow_q;
  logic [DRW-1:0] drain_q;

  logic take, run_px, primed, emit_px, last_px;

  assign in_ready = slot_free && (phase_q != PH_DRAIN);
  assign take     = in_valid && in_ready;
  assign run_px   = take && !in_sof && (phase_q == PH_RUN);
  assign lb_we    = take && (in_sof || (phase_q == PH_RUN));
  assign cur_col  = in_sof ? '0 : icol_q;

  // A result exists once the input has reached index IMG_W+1.
  assign primed    = (irow_q > RWD'(1)) || ((irow_q == RWD'(1)) && (icol_q != '0));
  assign emit_px   = run_px && primed;
  assign emit_zero = (phase_q == PH_DRAIN) && slot_free;
  assign emit      = emit_px || emit_zero;
  assign last_px   = run_px && (irow_q == LAST_ROW) && (icol_q == LAST_COL);

  assign emit_border = (orow_q == '0) || (orow_q == LAST_ROW) ||
                       (ocol_q == '0) || (ocol_q == LAST_COL);
  assign emit_first  = (orow_q == '0) && (ocol_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      icol_q  <= '0;
      irow_q  <= '0;
      ocol_q  <= '0;
      orow_q  <= '0;
      drain_q <= '0;
    end else if (take && in_sof) begin
      phase_q <= PH_RUN;
      icol_q  <= CW'(1);
      irow_q  <= '0;
      ocol_q  <= '0;
      orow_q  <= '0;
    end else begin
      if (run_px) begin
        if (icol_q == LAST_COL) begin
          icol_q <= '0;
          irow_q <= (irow_q == LAST_ROW) ? '0 : irow_q + RWD'(1);
        end else begin
          icol_q <= icol_q + CW'(1);
        end
        if (last_px) begin
          phase_q <= PH_DRAIN;
          drain_q <= DRW'(LAG);
        end
      end
      if (emit) begin
        if (ocol_q == LAST_COL) begin
          ocol_q <= '0;
          orow_q <= (orow_q == LAST_ROW) ? '0 : orow_q + RWD'(1);
        end else begin
          ocol_q <= ocol_q + CW'(1);
        end
      end
      if (emit_zero) begin
        drain_q <= drain_q - DRW'(1);
        if (drain_q == DRW'(1)) phase_q <= PH_IDLE;
      end
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (icol_q < CW'(IMG_W)) && (irow_q < RWD'(IMG_H)) &&
    (ocol_q < CW'(IMG_W)) && (orow_q < RWD'(IMG_H))); // R3

  AST_LAST_PIXEL_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    last_px |=> !in_ready); // R5

endmodule

// File: rtl/edge_binarizer.sv
`timescale 1ns/1ps
module edge_binarizer
  import ebin_pkg::*;
#(
  parameter int IMG_W = 20,
  parameter int IMG_H = 12,
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PIX_W+2:0] thresh,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_pix,
  input  logic                    in_sof,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_edge,
  output logic                    out_sof
);

  localparam int RW   = PIX_W + 3;
  localparam int CW   = $clog2(IMG_W);
  localparam int PEAK = resp_peak(PIX_W);

  logic                       slot_free, lb_we, emit, emit_zero, emit_border, emit_first;
  logic [CW-1:0]              cur_col;
  logic [1:0][PIX_W-1:0]      above;
  logic [PIX_W-1:0]           up_q, mid1_q, mid2_q, dn_q;
  logic signed [RW-1:0]       resp;
  logic                       hit;

  assign slot_free = !out_valid || out_ready;

  ebin_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .slot_free   (slot_free),
    .in_ready    (in_ready),
    .lb_we       (lb_we),
    .cur_col     (cur_col),
    .emit        (emit),
    .emit_zero   (emit_zero),
    .emit_border (emit_border),
    .emit_first  (emit_first)
  );

  ebin_line_store #(.DEPTH(IMG_W), .DW(PIX_W), .ROWS(2)) u_rows (
    .clk   (clk),
    .we    (lb_we),
    .col   (cur_col),
    .pix   (in_pix),
    .above (above)
  );

  // Window centred one row up and one column left of the incoming pixel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= '0;
      mid1_q <= '0;
      mid2_q <= '0;
      dn_q   <= '0;
    end else if (lb_we) begin
      up_q   <= above[1];
      mid1_q <= above[0];
      mid2_q <= mid1_q;
      dn_q   <= in_pix;
    end
  end

  ebin_cross_eval #(.DW(PIX_W), .RW(RW)) u_eval (
    .up    (up_q),
    .left  (mid2_q),
    .ctr   (mid1_q),
    .right (above[0]),
    .down  (dn_q),
    .thr   (thresh),
    .resp  (resp),
    .hit   (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_edge  <= 1'b0;
      out_sof   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_edge  <= !emit_zero && !emit_border && hit;
      out_sof   <= emit_first;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_edge) && $stable(out_sof))); // R6

  AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_SOF_AT_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !out_edge); // R4

  AST_RESP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> ((resp <= RW'(PEAK)) && (resp >= -RW'(PEAK)))); // R1

endmodule

// File: tb/edge_binarizer_tb.sv
`timescale 1ns/1ps
module edge_binarizer_tb;

  localparam int W   = 20;
  localparam int H   = 12;
  localparam int HW  = W * H;
  localparam int LAG = W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [10:0] thresh;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_pix = '0;
  logic              in_sof = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_edge;
  logic              out_sof;

  edge_binarizer #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh    (thresh),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pix    (in_pix),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_edge  (out_edge),
    .out_sof   (out_sof)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, out_seen = 0, rdy_pct = 100, thr_i = 30;
  int acc_lag_cyc = -1, sof_cyc = -1;
  logic [7:0] img [H][W];
  logic [1:0] exp_q [$];

  assign thresh = 11'(thr_i);

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk); #1;
    out_ready = ($urandom_range(99) < rdy_pct);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      out_seen++;
      if (out_sof) sof_cyc = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected result", 1, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(out_edge == e[0], "R2/R3 edge value", int'(out_edge), int'(e[0]));
        chk(out_sof == e[1], "R4 start marker", int'(out_sof), int'(e[1]));
      end
    end
  end

  function automatic bit exp_at(input int r, input int c);
    int s;
    if (r == 0 || r == H-1 || c == 0 || c == W-1) return 1'b0;
    s = 4 * int'(img[r][c]) - int'(img[r-1][c]) - int'(img[r+1][c])
        - int'(img[r][c-1]) - int'(img[r][c+1]);
    return s >= thr_i;
  endfunction

  task automatic push_exp(input int n);
    for (int j = 0; j < n; j++) exp_q.push_back({j == 0, exp_at(j / W, j % W)});
  endtask

  task automatic fill_flat(input int v);
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 8'(v);
  endtask

  task automatic fill_rand(input bit binary);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = binary ? (($urandom_range(1) != 0) ? 8'd255 : 8'd0) : 8'($urandom_range(255));
  endtask

  task automatic send_px(input logic [7:0] p, input bit sof, input int gap);
    bit hs;
    while ($urandom_range(99) < gap) begin
      in_valid = 1'b0; @(posedge clk); #1;
    end
    in_valid = 1'b1; in_pix = p; in_sof = sof;
    hs = 1'b0;
    while (!hs) begin
      @(negedge clk); hs = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_range(input int lo, input int hi, input int gap);
    for (int k = lo; k <= hi; k++) begin
      send_px(img[k / W][k % W], k == 0, gap);
      if (k == LAG) acc_lag_cyc = cyc;
    end
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
  endtask

  task automatic full_frame(input int gap, input int rdy);
    rdy_pct = rdy;
    push_exp(HW);
    send_range(0, HW - 1, gap);
    wait_drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seen0;
    logic hold_e;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

    // R8: stray pixels with no open frame
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) send_px(8'(i * 40), 1'b0, 0);
    repeat (10) @(posedge clk);
    chk(out_seen == 0, "R8 stray pixels dropped", out_seen, 0);

    // R5: exact lag and flush with a free output
    thr_i = 30; fill_rand(1'b0);
    seen0 = out_seen; rdy_pct = 100;
    push_exp(HW);
    send_range(0, HW - 1, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 input closed during flush", int'(in_ready), 0);
    wait_drain();
    chk(sof_cyc == acc_lag_cyc, "R5 first result lag", sof_cyc, acc_lag_cyc);
    chk(out_seen - seen0 == HW, "R3 results per frame", out_seen - seen0, HW);

    // R2: response exactly at and just above the threshold
    fill_flat(100); img[5][7] = 8'd108;
    thr_i = 32; full_frame(0, 100);
    thr_i = 33; full_frame(0, 100);
    fill_flat(77); thr_i = 0; full_frame(0, 100);

    // R1: extreme responses of both signs
    fill_flat(0); img[4][4] = 8'd255; thr_i = 30; full_frame(10, 80);
    fill_flat(255); img[6][9] = 8'd0; thr_i = 255; full_frame(10, 80);
    thr_i = -1020; fill_rand(1'b1); full_frame(0, 100);

    // R6: stalled consumer
    thr_i = 30; fill_rand(1'b1);
    push_exp(HW); rdy_pct = 0;
    @(posedge clk); #1;
    send_range(0, LAG, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 result presented", int'(out_valid), 1);
    hold_e = out_edge;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
    chk(out_edge == hold_e, "R6 edge held", int'(out_edge), int'(hold_e));
    chk(in_ready == 1'b0, "R6 input blocked", int'(in_ready), 0);
    rdy_pct = 100;
    send_range(LAG + 1, HW - 1, 10);
    wait_drain();

    // R7: abandon a frame part-way
    fill_rand(1'b0); rdy_pct = 70;
    push_exp(3 * W + 5 - LAG);
    send_range(0, 3 * W + 4, 20);
    fill_rand(1'b0);
    full_frame(20, 70);

    // random frames with gaps and back-pressure
    for (int f = 0; f < 6; f++) begin
      thr_i = $urandom_range(250) - 50;
      fill_rand(f[0]);
      full_frame(25, 60);
    end

    // R8: idle again after a completed flush
    seen0 = out_seen;
    for (int i = 0; i < 4; i++) send_px(8'd200, 1'b0, 0);
    repeat (10) @(posedge clk);
    chk(out_seen == seen0, "R8 idle after flush", out_seen - seen0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule